// File: doc/BRIEF.md
# Write-Protect and Status Unit for a Serial EEPROM

This unit owns the status byte of a small serial EEPROM and acts as the gatekeeper for every change to non-volatile content. It holds a write-enable latch and two block-protect bits. It also runs a self-timed programming interval, and a busy flag reports that interval. The command engine sends single-cycle strobes for enable, disable, array write and status write. The unit answers each write strobe in the same cycle with a grant or a deny pulse.

Three independent guards must all agree before a write proceeds:
- the enable latch, which clears itself after each granted write;
- an external active-low write-protect pin;
- an address-range filter driven by the block-protect bits.

The engine asks the filter about each byte of a page while it programs the page. Bytes that fall inside a protected range are dropped and the rest of the page is still written.

The programming time is a parameterised number of clock cycles. A soft reset models a supply dip: it clears the volatile state (enable latch, busy, pending job). The block-protect bits keep their values, as non-volatile cells would.

Top module: `wp_status_unit`

## Requirements
- R1: `status` is {4'b1111, BP1, BP0, WEL, BUSY} from bit 7 down to bit 0. After `rst` it reads 8'hF0.
- R2: A pulse on `wren_stb` sets WEL at the next edge and a pulse on `wrdi_stb` clears it. If both arrive together, the clear wins. While BUSY is 1, both strobes are ignored.
- R3: If WEL is 0, a pulse on `wr_start` or `sr_start` is answered by a deny pulse in the same cycle, and BUSY stays 0.
- R4: A granted start clears WEL and sets BUSY at the next edge.
- R5: While `wp_n` is 0, both starts are denied. Driving `wp_n` to 0 during BUSY does not shorten the cycle.
- R6: After a grant, BUSY stays 1 for exactly WRITE_CYCLES cycles. Any start during BUSY is denied.
- R7: A granted status write captures `sr_bp` and loads it into BP at the edge that ends BUSY. BP does not change earlier.
- R8: `byte_ok` is 0 for a protected address. With 9-bit addresses: BP=00 protects nothing, 01 protects 180h-1FFh, 10 protects 100h-1FFh, 11 protects every address.
- R9: `soft_rst` clears WEL and BUSY at the next edge and cancels a pending BP update. BP keeps its value.
- R10: If `wr_start` and `sr_start` arrive in the same cycle, the array write takes precedence and the status write is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high, clears everything |
| soft_rst | input | 1 | Synchronous reset of volatile state only |
| wren_stb | input | 1 | Set the write-enable latch |
| wrdi_stb | input | 1 | Clear the write-enable latch |
| wr_start | input | 1 | Request to start an array programming cycle |
| sr_start | input | 1 | Request to start a status programming cycle |
| sr_bp | input | 2 | Block-protect value offered with `sr_start` |
| wp_n | input | 1 | Write-protect pin, active low |
| byte_addr | input | ADDR_W | Address of the byte being programmed |
| status | output | 8 | Status byte |
| wr_grant | output | 1 | Array write accepted |
| wr_deny | output | 1 | Array write refused |
| sr_grant | output | 1 | Status write accepted |
| sr_deny | output | 1 | Status write refused |
| byte_ok | output | 1 | Address is outside the protected range |

## Verification
The assertions take the strobes as single-cycle pulses that the command engine drives only between edges. They also take `rst` as held for at least one edge before any check applies. The bench drives every input on the falling edge and holds each strobe for one cycle only. It changes `sr_bp` only together with `sr_start`, and it uses `soft_rst` only as a lone pulse. Under these conditions the busy-length counter and the BP-stability checks see clean windows.

// File: rtl/wpsu_pkg.sv
package wpsu_pkg;

    typedef struct packed {
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } wpsu_state_t;

    typedef enum logic [1:0] {
        JOB_IDLE   = 2'd0,
        JOB_ARRAY  = 2'd1,
        JOB_STATUS = 2'd2
    } wpsu_job_e;

    // Protected-range decode from the two most significant address bits.
    function automatic logic addr_locked(input logic [1:0] bp, input logic [1:0] top2);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return (top2 == 2'b11);
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(input wpsu_state_t s);
        return {4'b1111, s.bp, s.wel, s.busy};
    endfunction

endpackage

// File: rtl/wpsu_enable_latch.sv
module wpsu_enable_latch (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic set_stb,
    input  logic clr_stb,
    input  logic consume,
    input  logic busy,
    output logic wel
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            wel <= 1'b0;
        end else if (consume) begin
            wel <= 1'b0;
        end else if (!busy) begin
            if (clr_stb)      wel <= 1'b0;
            else if (set_stb) wel <= 1'b1;
        end
    end
endmodule

// File: rtl/wpsu_cycle_timer.sv
module wpsu_cycle_timer #(
    parameter int unsigned CYCLES = 200000
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] remain;

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (clr) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= LOAD;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/wpsu_range_check.sv
module wpsu_range_check
    import wpsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              allowed
);
    logic [1:0] top2;
    assign top2    = addr[ADDR_W-1 -: 2];
    assign allowed = !addr_locked(bp, top2);
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit
    import wpsu_pkg::*;
#(
    parameter int unsigned ADDR_W       = 9,
    parameter int unsigned WRITE_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wren_stb,
    input  logic              wrdi_stb,
    input  logic              wr_start,
    input  logic              sr_start,
    input  logic [1:0]        sr_bp,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        status,
    output logic              wr_grant,
    output logic              wr_deny,
    output logic              sr_grant,
    output logic              sr_deny,
    output logic              byte_ok
);
    wpsu_state_t st;
    wpsu_job_e   job;
    logic [1:0]  bp_q, bp_pend;
    logic        wel, busy, done, may_write, any_grant;

    assign may_write = wel && wp_n && !busy;
    assign wr_grant  = wr_start && may_write;
    assign wr_deny   = wr_start && !may_write;
    assign sr_grant  = sr_start && !wr_start && may_write;
    assign sr_deny   = sr_start && !sr_grant;
    assign any_grant = wr_grant || sr_grant;

    wpsu_enable_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set_stb  (wren_stb),
        .clr_stb  (wrdi_stb),
        .consume  (any_grant),
        .busy     (busy),
        .wel      (wel)
    );

    wpsu_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .clr   (rst || soft_rst),
        .start (any_grant),
        .busy  (busy),
        .done  (done)
    );

    wpsu_range_check #(.ADDR_W(ADDR_W)) u_range (
        .bp      (bp_q),
        .addr    (byte_addr),
        .allowed (byte_ok)
    );

    // BP is non-volatile: only the power-on reset clears it.
    always_ff @(posedge clk) begin
        if (rst) begin
            bp_q    <= 2'b00;
            bp_pend <= 2'b00;
            job     <= JOB_IDLE;
        end else if (soft_rst) begin
            job     <= JOB_IDLE;
        end else if (sr_grant) begin
            bp_pend <= sr_bp;
            job     <= JOB_STATUS;
        end else if (wr_grant) begin
            job     <= JOB_ARRAY;
        end else if (done) begin
            if (job == JOB_STATUS) bp_q <= bp_pend;
            job <= JOB_IDLE;
        end
    end

    always_comb begin
        st.bp   = bp_q;
        st.wel  = wel;
        st.busy = busy;
        status  = pack_status(st);
    end
endmodule

// File: rtl/wpsu_checker.sv
module wpsu_checker #(
    parameter int unsigned WRITE_CYCLES = 200000
) (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       wp_n,
    input logic [7:0] status,
    input logic       wr_grant,
    input logic       sr_grant,
    input logic       wr_start,
    input logic       byte_ok
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !status[0]) run_len <= '0;
        else                   run_len <= run_len + 1;
    end

    // R1: upper nibble is fixed
    a_r1_fixed_nibble: assert property (@(posedge clk) disable iff (rst)
        status[7:4] == 4'hF);

    // R4: a grant consumes the latch and starts the cycle
    a_r4_grant_starts: assert property (@(posedge clk) disable iff (rst)
        (wr_grant || sr_grant) && !soft_rst |=> status[0] && !status[1]);

    // R5: pin inhibit blocks both grants
    a_r5_pin_blocks: assert property (@(posedge clk) disable iff (rst)
        !wp_n |-> !wr_grant && !sr_grant);

    // R6: busy never outlasts the programming time
    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        status[0] |-> run_len < WRITE_CYCLES);

    // R7: BP holds while a cycle is under way
    a_r7_bp_held: assert property (@(posedge clk) disable iff (rst)
        status[0] && $past(status[0]) |-> $stable(status[3:2]));

    // R8: full protection refuses every address
    a_r8_full_lock: assert property (@(posedge clk) disable iff (rst)
        status[3:2] == 2'b11 |-> !byte_ok);

    // R9: soft reset clears volatile state and keeps BP
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !status[0] && !status[1] && $stable(status[3:2]));

    // R10: status write never granted alongside an array write request
    a_r10_array_first: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> !sr_grant);
endmodule

bind wp_status_unit wpsu_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_wpsu_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .wp_n     (wp_n),
    .status   (status),
    .wr_grant (wr_grant),
    .sr_grant (sr_grant),
    .wr_start (wr_start),
    .byte_ok  (byte_ok)
);

// File: tb/test_wp_status_unit.sv
module test_wp_status_unit;
    localparam int WC = 16;

    logic       clk = 1'b0;
    logic       rst, soft_rst, wren_stb, wrdi_stb, wr_start, sr_start, wp_n;
    logic [1:0] sr_bp;
    logic [8:0] byte_addr;
    logic [7:0] status;
    logic       wr_grant, wr_deny, sr_grant, sr_deny, byte_ok;

    int checks = 0;
    int fails  = 0;
    logic [1:0] cur_bp = 2'b00;

    always #10 clk = ~clk;

    wp_status_unit #(.ADDR_W(9), .WRITE_CYCLES(WC)) i_wp_status_unit (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wren_stb(wren_stb),
        .wrdi_stb(wrdi_stb), .wr_start(wr_start), .sr_start(sr_start),
        .sr_bp(sr_bp), .wp_n(wp_n), .byte_addr(byte_addr), .status(status),
        .wr_grant(wr_grant), .wr_deny(wr_deny), .sr_grant(sr_grant),
        .sr_deny(sr_deny), .byte_ok(byte_ok)
    );

    // {bp[1:0], addr[8:0], expected byte_ok}
    localparam logic [11:0] VEC [12] = '{
        {2'd0, 9'h000, 1'b1}, {2'd0, 9'h1FF, 1'b1},
        {2'd1, 9'h17F, 1'b1}, {2'd1, 9'h180, 1'b0},
        {2'd1, 9'h1FF, 1'b0}, {2'd1, 9'h0A5, 1'b1},
        {2'd2, 9'h0FF, 1'b1}, {2'd2, 9'h100, 1'b0},
        {2'd2, 9'h17F, 1'b0}, {2'd3, 9'h000, 1'b0},
        {2'd3, 9'h0FF, 1'b0}, {2'd3, 9'h1FF, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_wren();
        wren_stb = 1'b1; tick(); wren_stb = 1'b0;
    endtask

    task automatic set_bp(input logic [1:0] b);
        do_wren();
        sr_start = 1'b1; sr_bp = b; #1;
        chk("R7 grant", {31'd0, sr_grant}, 32'd1);
        tick(); sr_start = 1'b0;
        tick();
        chk("R7 bp held mid-cycle", {30'd0, status[3:2]}, {30'd0, cur_bp});
        while (status[0]) tick();
        cur_bp = b;
        chk("R7 bp loaded", {24'd0, status}, {24'd0, 4'hF, b, 2'b00});
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; soft_rst = 1'b0; wren_stb = 1'b0; wrdi_stb = 1'b0;
        wr_start = 1'b0; sr_start = 1'b0; sr_bp = 2'b00; wp_n = 1'b1;
        byte_addr = '0;
        tick(); tick(); rst = 1'b0; tick();

        // R1 reset value
        chk("R1 reset status", {24'd0, status}, 32'hF0);

        // R3 start with latch clear
        wr_start = 1'b1; #1;
        chk("R3 wr_deny", {31'd0, wr_deny}, 32'd1);
        chk("R3 wr_grant", {31'd0, wr_grant}, 32'd0);
        tick(); wr_start = 1'b0;
        chk("R3 no busy", {24'd0, status}, 32'hF0);

        // R2 enable, disable, simultaneous
        do_wren();
        chk("R2 set", {24'd0, status}, 32'hF2);
        wrdi_stb = 1'b1; tick(); wrdi_stb = 1'b0;
        chk("R2 clear", {24'd0, status}, 32'hF0);
        wren_stb = 1'b1; wrdi_stb = 1'b1; tick(); wren_stb = 1'b0; wrdi_stb = 1'b0;
        chk("R2 clear wins", {24'd0, status}, 32'hF0);

        // R5 pin inhibit
        do_wren();
        wp_n = 1'b0; wr_start = 1'b1; #1;
        chk("R5 wr denied", {30'd0, wr_deny, wr_grant}, 32'd2);
        wr_start = 1'b0; sr_start = 1'b1; #1;
        chk("R5 sr denied", {30'd0, sr_deny, sr_grant}, 32'd2);
        tick(); sr_start = 1'b0; wp_n = 1'b1;
        chk("R5 latch kept", {24'd0, status}, 32'hF2);

        // R10 and R4
        wr_start = 1'b1; sr_start = 1'b1; sr_bp = 2'b11; #1;
        chk("R10 array granted", {31'd0, wr_grant}, 32'd1);
        chk("R10 status denied", {30'd0, sr_deny, sr_grant}, 32'd2);
        tick(); wr_start = 1'b0; sr_start = 1'b0;
        chk("R4 busy and latch cleared", {24'd0, status}, 32'hF1);

        // R6 busy length; R5 pin mid-cycle; R2 ignored while busy
        begin
            int n = 0;
            while (status[0] && n < 100) begin
                n++;
                wren_stb = (n == 3);
                wp_n     = !(n == 4);
                wr_start = (n == 6);
                #1;
                if (n == 6) chk("R6 start during busy denied", {31'd0, wr_deny}, 32'd1);
                tick();
            end
            wren_stb = 1'b0; wr_start = 1'b0; wp_n = 1'b1;
            chk("R6 busy length", n, WC);
            chk("R2 wren ignored while busy", {24'd0, status}, 32'hF0);
        end

        // R8 table walk, R7 status writes
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][11:10] != cur_bp) set_bp(VEC[i][11:10]);
            byte_addr = VEC[i][9:1]; #1;
            chk("R8 byte_ok", {31'd0, byte_ok}, {31'd0, VEC[i][0]});
            tick();
        end

        // R9 soft reset keeps BP and cancels pending update
        set_bp(2'b10);
        do_wren();
        sr_start = 1'b1; sr_bp = 2'b01; tick(); sr_start = 1'b0;
        tick(); tick();
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        chk("R9 volatile cleared", {24'd0, status}, 32'hF8);
        repeat (WC + 4) tick();
        chk("R9 pending cancelled", {24'd0, status}, 32'hF8);

        // R1 power-on reset clears BP
        rst = 1'b1; tick(); rst = 1'b0; tick();
        chk("R1 full reset", {24'd0, status}, 32'hF0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule